// File: doc/BRIEF.md
# Boundary-Scan Test Controller with Signature Modes

This block is the test logic that sits around a small bidirectional datapath. It is driven from a four-wire serial test port: TCK, TMS, TDI and TDO. A sixteen-state controller steps on TMS and selects one of three scan paths. The first is an 8-bit instruction register whose opcodes must have even parity. The second is a 32-bit identification register. The third is a single-bit bypass stage. There is also a boundary register with exactly one cell per functional pin: input cells for the pins entering the core and output cells for the pins leaving it.

Under the observation instructions (sample, bypass, identification) the functional path runs undisturbed. Under the test instructions the block takes over the boundary. The value driven at the output pins, the pin enable and the value presented to the core all come from the boundary register's update stage.

Four extra instructions reuse the boundary register at each pass through Update-DR:

- a parallel signature compressor on the input cells;
- a pseudo-random generator on the output cells;
- a binary counter on the output cells, run alongside compression;
- an input-sample-and-output-invert mode.

A nonzero seed is loaded by shifting it in, and Capture-DR holds the register in these modes so that the result can be shifted out afterwards.

Top module: `bscan_sig_ctl`

## Requirements
- R1: From any controller state, five rising TCK edges with TMS high reach Test-Logic-Reset. Reset (or the power-on reset `por_n` low) selects the identification instruction. With that instruction, a DR scan shifts out the 32-bit `ID_VALUE` least significant bit first, and the pins follow the functional path.
- R2: During an instruction scan, the instruction register first shifts out the capture pattern 8'h01, least significant bit first. TDI enters the top bit and TDO shows bit 0.
- R3: An opcode with odd parity is applied as bypass: a 1-bit data path, and the pins follow the functional path.
- R4: Bypass (opcode 8'hFF) selects a 1-bit register that captures 0. Data on TDI reappears at TDO one shift later.
- R5: Sample (8'h82) loads cell k (k < NI) from `sys_in[k]` and cell NI+j from `core_out[j]` at Capture-DR. Cell 0 is next to TDO and TDI enters the top cell. The pins and `core_in` keep following the functional path.
- R6: External test (8'h00) drives `pin_out` from the updated output cells and `pin_oe` high, and drives `core_in` from the updated input cells. The change takes effect on the edge that leaves Update-IR or Update-DR, and `core_out` has no effect on the pins.
- R7: Clamp (8'h87) holds the last updated pin values and the enable, and selects the bypass register.
- R8: High-impedance (8'h88) drives `pin_oe` low and selects the bypass register.
- R9: Signature mode (8'h8B) does the following on each Update-DR: input cells become step(cells) XOR `sys_in`. Here step is a Galois right shift: shift right by one, then XOR with mask `TAPS_IN` (8'hB8 by default) when the bit shifted out was 1. Capture-DR leaves the register unchanged.
- R10: Pattern mode (8'h8D) advances the output cells by the same step with mask `TAPS_OUT` on each Update-DR and drives them onto `pin_out`. A nonzero state never becomes zero.
- R11: Count mode (8'h8E) compresses the input cells as in R9 and increments the output cells by one, modulo 2^NO, on each Update-DR.
- R12: Toggle mode (8'h90) loads the input cells from `sys_in` and inverts the output cells on each Update-DR.
- R13: TDO changes on the falling TCK edge. It is 0 whenever the controller is in neither Shift-DR nor Shift-IR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| por_n | input | 1 | Asynchronous power-on reset of the test logic, active low |
| tck | input | 1 | Test clock |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial test data in |
| tdo | output | 1 | Serial test data out, changes on falling TCK |
| sys_in | input | NI | Values arriving at the input pins |
| core_in | output | NI | Values presented to the core logic |
| core_out | input | NO | Values the core wants to drive |
| core_oe | input | 1 | Output enable requested by the core |
| pin_out | output | NO | Values driven to the output pins |
| pin_oe | output | 1 | Output pin enable |

## Verification
A wrong instruction decode shows up at the pins on the TCK edge that leaves Update-IR. At that edge `pin_oe`, `pin_out` or `core_in` either moves away from the functional path or fails to move away from it. A wrong data-register selection shows up in the first bits of the next scan: bypass produces a leading 0 followed by the delayed TDI stream, whereas the identification path produces its fixed pattern. A faulty step in any signature or counting mode appears on `pin_out` or `core_in` on the edge that leaves Update-DR, and it grows with every further pass. A later scan-out, taken without any intervening capture, exposes the accumulated value bit by bit.

// File: rtl/bscan_pkg.sv
package bscan_pkg;

   localparam int unsigned IR_W = 8;

   typedef enum logic [3:0] {
      TS_RESET, TS_IDLE,
      TS_SEL_DR, TS_CAP_DR, TS_SH_DR, TS_EX1_DR, TS_PAUSE_DR, TS_EX2_DR, TS_UPD_DR,
      TS_SEL_IR, TS_CAP_IR, TS_SH_IR, TS_EX1_IR, TS_PAUSE_IR, TS_EX2_IR, TS_UPD_IR
   } tap_st_t;

   typedef enum logic [3:0] {
      MD_EXTEST, MD_BYPASS, MD_SAMPLE, MD_IDCODE, MD_CLAMP,
      MD_HIGHZ, MD_PSA, MD_PRPG, MD_PSACNT, MD_TOGGLE
   } mode_t;

   localparam logic [IR_W-1:0] OP_EXTEST  = 8'h00;
   localparam logic [IR_W-1:0] OP_BYPASS  = 8'hFF;
   localparam logic [IR_W-1:0] OP_SAMPLE  = 8'h82;
   localparam logic [IR_W-1:0] OP_IDCODE  = 8'h84;
   localparam logic [IR_W-1:0] OP_CLAMP   = 8'h87;
   localparam logic [IR_W-1:0] OP_HIGHZ   = 8'h88;
   localparam logic [IR_W-1:0] OP_PSA     = 8'h8B;
   localparam logic [IR_W-1:0] OP_PRPG    = 8'h8D;
   localparam logic [IR_W-1:0] OP_PSACNT  = 8'h8E;
   localparam logic [IR_W-1:0] OP_TOGGLE  = 8'h90;
   localparam logic [IR_W-1:0] IR_CAPTURE = 8'h01;

   // odd parity or unknown code falls back to bypass
   function automatic mode_t decode_op(input logic [IR_W-1:0] op);
      mode_t m;
      m = MD_BYPASS;
      if (^op == 1'b0) begin
         case (op)
            OP_EXTEST: m = MD_EXTEST;
            OP_SAMPLE: m = MD_SAMPLE;
            OP_IDCODE: m = MD_IDCODE;
            OP_CLAMP:  m = MD_CLAMP;
            OP_HIGHZ:  m = MD_HIGHZ;
            OP_PSA:    m = MD_PSA;
            OP_PRPG:   m = MD_PRPG;
            OP_PSACNT: m = MD_PSACNT;
            OP_TOGGLE: m = MD_TOGGLE;
            default:   m = MD_BYPASS;
         endcase
      end
      return m;
   endfunction

   function automatic logic owns_pins(input mode_t m);
      return (m == MD_EXTEST) || (m == MD_CLAMP) || (m == MD_HIGHZ) ||
             (m == MD_PSA) || (m == MD_PRPG) || (m == MD_PSACNT) || (m == MD_TOGGLE);
   endfunction

   function automatic logic uses_bsr(input mode_t m);
      return (m == MD_EXTEST) || (m == MD_SAMPLE) || (m == MD_PSA) ||
             (m == MD_PRPG) || (m == MD_PSACNT) || (m == MD_TOGGLE);
   endfunction

   function automatic logic self_running(input mode_t m);
      return (m == MD_PSA) || (m == MD_PRPG) || (m == MD_PSACNT) || (m == MD_TOGGLE);
   endfunction

endpackage

// File: rtl/bscan_tap.sv
module bscan_tap
   import bscan_pkg::*;
(
   input  logic    tck,
   input  logic    por_n,
   input  logic    tms,
   output tap_st_t state
);

   tap_st_t nxt;

   always_comb begin
      case (state)
         TS_RESET:    nxt = tms ? TS_RESET   : TS_IDLE;
         TS_IDLE:     nxt = tms ? TS_SEL_DR  : TS_IDLE;
         TS_SEL_DR:   nxt = tms ? TS_SEL_IR  : TS_CAP_DR;
         TS_CAP_DR:   nxt = tms ? TS_EX1_DR  : TS_SH_DR;
         TS_SH_DR:    nxt = tms ? TS_EX1_DR  : TS_SH_DR;
         TS_EX1_DR:   nxt = tms ? TS_UPD_DR  : TS_PAUSE_DR;
         TS_PAUSE_DR: nxt = tms ? TS_EX2_DR  : TS_PAUSE_DR;
         TS_EX2_DR:   nxt = tms ? TS_UPD_DR  : TS_SH_DR;
         TS_UPD_DR:   nxt = tms ? TS_SEL_DR  : TS_IDLE;
         TS_SEL_IR:   nxt = tms ? TS_RESET   : TS_CAP_IR;
         TS_CAP_IR:   nxt = tms ? TS_EX1_IR  : TS_SH_IR;
         TS_SH_IR:    nxt = tms ? TS_EX1_IR  : TS_SH_IR;
         TS_EX1_IR:   nxt = tms ? TS_UPD_IR  : TS_PAUSE_IR;
         TS_PAUSE_IR: nxt = tms ? TS_EX2_IR  : TS_PAUSE_IR;
         TS_EX2_IR:   nxt = tms ? TS_UPD_IR  : TS_SH_IR;
         TS_UPD_IR:   nxt = tms ? TS_SEL_DR  : TS_IDLE;
         default:     nxt = TS_RESET;
      endcase
   end

   always_ff @(posedge tck or negedge por_n) begin
      if (!por_n) state <= TS_RESET;
      else        state <= nxt;
   end

   // run of consecutive TMS-high edges, saturating at five
   logic [2:0] hi_run;
   always_ff @(posedge tck or negedge por_n) begin
      if (!por_n)                hi_run <= 3'd0;
      else if (!tms)             hi_run <= 3'd0;
      else if (hi_run != 3'd5)   hi_run <= hi_run + 3'd1;
   end

   // R1
   tlr_after_five_chk: assert property (@(posedge tck) disable iff (!por_n)
      (hi_run == 3'd5) |-> (state == TS_RESET));

endmodule

// File: rtl/bscan_ir.sv
module bscan_ir
   import bscan_pkg::*;
(
   input  logic    tck,
   input  logic    por_n,
   input  tap_st_t state,
   input  logic    tdi,
   output logic    ir_lsb,
   output mode_t   mode
);

   logic [IR_W-1:0] ir_sr;

   always_ff @(posedge tck or negedge por_n) begin
      if (!por_n) begin
         ir_sr <= '0;
         mode  <= MD_IDCODE;
      end else begin
         case (state)
            TS_RESET:  mode  <= MD_IDCODE;
            TS_CAP_IR: ir_sr <= IR_CAPTURE;
            TS_SH_IR:  ir_sr <= {tdi, ir_sr[IR_W-1:1]};
            TS_UPD_IR: mode  <= decode_op(ir_sr);
            default: ;
         endcase
      end
   end

   assign ir_lsb = ir_sr[0];

   // R3
   odd_parity_bypass_chk: assert property (@(posedge tck) disable iff (!por_n)
      (state == TS_UPD_IR && (^ir_sr)) |=> (mode == MD_BYPASS));

   // R1
   reset_selects_id_chk: assert property (@(posedge tck) disable iff (!por_n)
      (state == TS_RESET) |=> (mode == MD_IDCODE));

endmodule

// File: rtl/bscan_bsr.sv
module bscan_bsr
   import bscan_pkg::*;
#(
   parameter int unsigned    NI       = 8,
   parameter int unsigned    NO       = 8,
   parameter logic [NI-1:0]  TAPS_IN  = 'hB8,
   parameter logic [NO-1:0]  TAPS_OUT = 'hB8
) (
   input  logic            tck,
   input  logic            por_n,
   input  tap_st_t         state,
   input  mode_t           mode,
   input  logic            tdi,
   input  logic [NI-1:0]   sys_in,
   input  logic [NO-1:0]   core_out,
   output logic            sr_lsb,
   output logic [NI+NO-1:0] upd_q
);

   localparam int unsigned W = NI + NO;

   logic [W-1:0] sr_q;
   logic [W-1:0] cap_v;
   logic [W-1:0] nxt_v;
   logic         sel;
   logic         hold_cap;

   assign sel      = uses_bsr(mode);
   assign hold_cap = self_running(mode);

   // one cell per pin: input cells low, output cells high
   for (genvar k = 0; k < NI; k++) begin : g_in_cell
      assign cap_v[k] = sys_in[k];
   end
   for (genvar j = 0; j < NO; j++) begin : g_out_cell
      assign cap_v[NI+j] = core_out[j];
   end

   function automatic logic [NI-1:0] step_in(input logic [NI-1:0] s);
      return (s >> 1) ^ (s[0] ? TAPS_IN : '0);
   endfunction

   function automatic logic [NO-1:0] step_out(input logic [NO-1:0] s);
      return (s >> 1) ^ (s[0] ? TAPS_OUT : '0);
   endfunction

   logic [NI-1:0] sr_in;
   logic [NO-1:0] sr_out;
   assign sr_in  = sr_q[NI-1:0];
   assign sr_out = sr_q[W-1:NI];

   always_comb begin
      case (mode)
         MD_PSA:    nxt_v = {sr_out, step_in(sr_in) ^ sys_in};
         MD_PSACNT: nxt_v = {sr_out + 1'b1, step_in(sr_in) ^ sys_in};
         MD_PRPG:   nxt_v = {step_out(sr_out), sr_in};
         MD_TOGGLE: nxt_v = {~sr_out, sys_in};
         default:   nxt_v = sr_q;
      endcase
   end

   always_ff @(posedge tck or negedge por_n) begin
      if (!por_n) begin
         sr_q  <= '0;
         upd_q <= '0;
      end else begin
         case (state)
            TS_RESET: begin
               sr_q  <= '0;
               upd_q <= '0;
            end
            TS_CAP_DR: if (sel && !hold_cap) sr_q <= cap_v;
            TS_SH_DR:  if (sel) sr_q <= {tdi, sr_q[W-1:1]};
            TS_UPD_DR: if (sel) begin
               sr_q  <= nxt_v;
               upd_q <= nxt_v;
            end
            default: ;
         endcase
      end
   end

   assign sr_lsb = sr_q[0];

   // R5
   sample_capture_chk: assert property (@(posedge tck) disable iff (!por_n)
      (state == TS_CAP_DR && mode == MD_SAMPLE) |=> (sr_q == $past({core_out, sys_in})));

   // R10
   prpg_nonzero_chk: assert property (@(posedge tck) disable iff (!por_n)
      (state == TS_UPD_DR && mode == MD_PRPG && sr_out != '0) |=> (upd_q[W-1:NI] != '0));

   // R11
   count_step_chk: assert property (@(posedge tck) disable iff (!por_n)
      (state == TS_UPD_DR && mode == MD_PSACNT) |=> (upd_q[W-1:NI] == NO'($past(sr_out) + 1'b1)));

   // R12
   toggle_invert_chk: assert property (@(posedge tck) disable iff (!por_n)
      (state == TS_UPD_DR && mode == MD_TOGGLE) |=> (upd_q[W-1:NI] == ~$past(sr_out)));

endmodule

// File: rtl/bscan_sig_ctl.sv
module bscan_sig_ctl
   import bscan_pkg::*;
#(
   parameter int unsigned    NI       = 8,
   parameter int unsigned    NO       = 8,
   parameter logic [NI-1:0]  TAPS_IN  = 'hB8,
   parameter logic [NO-1:0]  TAPS_OUT = 'hB8,
   parameter logic [31:0]    ID_VALUE = 32'h4B17_A0C3
) (
   input  logic          por_n,
   input  logic          tck,
   input  logic          tms,
   input  logic          tdi,
   output logic          tdo,
   input  logic [NI-1:0] sys_in,
   output logic [NI-1:0] core_in,
   input  logic [NO-1:0] core_out,
   input  logic          core_oe,
   output logic [NO-1:0] pin_out,
   output logic          pin_oe
);

   localparam int unsigned ID_W = 32;
   localparam int unsigned W    = NI + NO;

   if (NI < 2 || NO < 2) begin : g_bad_width
      $error("boundary cell counts must be at least 2");
   end
   if (ID_VALUE[0] != 1'b1) begin : g_bad_id
      $error("identification value must end in 1");
   end
   if (TAPS_IN[NI-1] != 1'b1 || TAPS_OUT[NO-1] != 1'b1) begin : g_bad_taps
      $error("feedback masks need their top bit set");
   end

   tap_st_t      state;
   mode_t        mode;
   logic         ir_lsb;
   logic         bsr_lsb;
   logic [W-1:0] upd_q;

   bscan_tap u_tap (
      .tck   (tck),
      .por_n (por_n),
      .tms   (tms),
      .state (state)
   );

   bscan_ir u_ir (
      .tck    (tck),
      .por_n  (por_n),
      .state  (state),
      .tdi    (tdi),
      .ir_lsb (ir_lsb),
      .mode   (mode)
   );

   bscan_bsr #(
      .NI       (NI),
      .NO       (NO),
      .TAPS_IN  (TAPS_IN),
      .TAPS_OUT (TAPS_OUT)
   ) u_bsr (
      .tck      (tck),
      .por_n    (por_n),
      .state    (state),
      .mode     (mode),
      .tdi      (tdi),
      .sys_in   (sys_in),
      .core_out (core_out),
      .sr_lsb   (bsr_lsb),
      .upd_q    (upd_q)
   );

   // identification and bypass paths
   logic [ID_W-1:0] id_sr;
   logic            byp_q;

   always_ff @(posedge tck or negedge por_n) begin
      if (!por_n) begin
         id_sr <= '0;
         byp_q <= 1'b0;
      end else begin
         case (state)
            TS_CAP_DR: begin
               id_sr <= ID_VALUE;
               byp_q <= 1'b0;
            end
            TS_SH_DR: begin
               id_sr <= {tdi, id_sr[ID_W-1:1]};
               byp_q <= tdi;
            end
            default: ;
         endcase
      end
   end

   logic dr_lsb;
   always_comb begin
      if (uses_bsr(mode))        dr_lsb = bsr_lsb;
      else if (mode == MD_IDCODE) dr_lsb = id_sr[0];
      else                        dr_lsb = byp_q;
   end

   always_ff @(negedge tck or negedge por_n) begin
      if (!por_n)                 tdo <= 1'b0;
      else if (state == TS_SH_DR) tdo <= dr_lsb;
      else if (state == TS_SH_IR) tdo <= ir_lsb;
      else                        tdo <= 1'b0;
   end

   // boundary takeover
   logic take;
   assign take    = owns_pins(mode);
   assign pin_out = take ? upd_q[W-1:NI] : core_out;
   assign pin_oe  = (mode == MD_HIGHZ) ? 1'b0 : (take ? 1'b1 : core_oe);
   assign core_in = take ? upd_q[NI-1:0] : sys_in;

endmodule

// File: tb/sim_bscan_sig_ctl.sv
module sim_bscan_sig_ctl;

   localparam logic [31:0] ID  = 32'h4B17_A0C3;
   localparam logic [7:0]  TAP = 8'hB8;

   logic       tck = 1'b0;
   logic       por_n = 1'b0;
   logic       tms = 1'b1;
   logic       tdi = 1'b0;
   logic [7:0] sys_in = 8'h00;
   logic [7:0] core_out = 8'h00;
   logic       core_oe = 1'b0;
   logic       tdo;
   logic [7:0] core_in;
   logic [7:0] pin_out;
   logic       pin_oe;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   bscan_sig_ctl u0 (
      .por_n (por_n), .tck (tck), .tms (tms), .tdi (tdi), .tdo (tdo),
      .sys_in (sys_in), .core_in (core_in), .core_out (core_out),
      .core_oe (core_oe), .pin_out (pin_out), .pin_oe (pin_oe)
   );

   always #10 tck = ~tck;

   function automatic logic [7:0] step8(input logic [7:0] s);
      return (s >> 1) ^ (s[0] ? TAP : 8'h00);
   endfunction

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic tick(input logic m, input logic d, output logic o);
      tms = m;
      tdi = d;
      o = tdo;
      @(posedge tck);
      @(negedge tck);
      #1;
   endtask

   task automatic tk(input logic m);
      logic o;
      tick(m, 1'b0, o);
   endtask

   task automatic ir_scan(input logic [7:0] op, output logic [7:0] cap);
      tk(1); tk(1); tk(0); tk(0);
      for (int i = 0; i < 8; i++) begin
         logic o;
         tick(i == 7, op[i], o);
         cap[i] = o;
      end
      tk(1); tk(0);
   endtask

   task automatic load(input logic [7:0] op);
      logic [7:0] c;
      ir_scan(op, c);
   endtask

   task automatic dr_scan(input int n, input logic [63:0] din, output logic [63:0] dout);
      dout = '0;
      tk(1); tk(0); tk(0);
      for (int i = 0; i < n; i++) begin
         logic o;
         tick(i == n - 1, din[i], o);
         dout[i] = o;
      end
      tk(1); tk(0);
   endtask

   task automatic upd_pass();
      tk(1); tk(0); tk(1); tk(1); tk(0);
   endtask

   task automatic t_reset();
      logic [63:0] d;
      sys_in = 8'hA5; core_out = 8'h3C; core_oe = 1'b1;
      repeat (2) @(negedge tck);
      #1 por_n = 1'b1;
      chk("R13 tdo idle after reset", tdo, 0);
      chk("R1 pins functional after reset", {pin_oe, pin_out}, {1'b1, 8'h3C});
      chk("R1 core_in functional", core_in, 8'hA5);
      tk(0);
      dr_scan(32, 0, d);
      chk("R1 id shifted out", d[31:0], ID);
      chk("R13 tdo low in idle", tdo, 0);
   endtask

   task automatic t_tlr_from_shift();
      logic [63:0] d;
      load(8'h82);
      tk(1); tk(0); tk(0);
      repeat (5) tk(1);
      tk(0);
      dr_scan(32, 64'hFFFF_FFFF, d);
      chk("R1 five tms highs restore id", d[31:0], ID);
   endtask

   task automatic t_bypass();
      logic [7:0] c;
      logic [63:0] d;
      ir_scan(8'hFF, c);
      chk("R2 ir capture pattern", c, 8'h01);
      dr_scan(8, 64'hB2, d);
      chk("R4 bypass one stage", d[7:0], 8'h64);
   endtask

   task automatic t_parity();
      logic [63:0] d;
      load(8'h83);
      dr_scan(4, 64'hD, d);
      chk("R3 odd opcode acts as bypass", d[3:0], 4'hA);
      chk("R3 pins functional", pin_out, core_out);
   endtask

   task automatic t_sample();
      logic [63:0] d;
      sys_in = 8'hA5; core_out = 8'h3C;
      load(8'h82);
      dr_scan(16, 64'h1234, d);
      chk("R5 sample capture order", d[15:0], 16'h3CA5);
      chk("R5 pins undisturbed", {pin_oe, pin_out}, {1'b1, 8'h3C});
      chk("R5 core_in undisturbed", core_in, 8'hA5);
   endtask

   task automatic t_extest();
      logic [63:0] d;
      load(8'h00);
      chk("R6 takeover at instruction load", pin_out, 8'h12);
      dr_scan(16, 64'h965A, d);
      chk("R6 extest capture", d[15:0], 16'h3CA5);
      chk("R6 pins from cells", {pin_oe, pin_out}, {1'b1, 8'h96});
      chk("R6 core_in from cells", core_in, 8'h5A);
      core_out = 8'hFF; #1;
      chk("R6 core_out ignored", pin_out, 8'h96);
   endtask

   task automatic t_clamp_highz();
      logic [63:0] d;
      load(8'h87);
      dr_scan(3, 64'h3, d);
      chk("R7 clamp selects bypass", d[2:0], 3'h6);
      chk("R7 clamp holds pins", {pin_oe, pin_out}, {1'b1, 8'h96});
      load(8'h88);
      chk("R8 highz disables pins", pin_oe, 0);
      dr_scan(2, 64'h1, d);
      chk("R8 highz selects bypass", d[1:0], 2'h2);
   endtask

   task automatic t_psa();
      logic [63:0] d;
      logic [7:0] sig;
      load(8'h8B);
      sys_in = 8'h11;
      dr_scan(16, 64'h0001, d);
      sig = step8(8'h01) ^ 8'h11;
      chk("R9 first signature to core", core_in, sig);
      sys_in = 8'h22; upd_pass(); sig = step8(sig) ^ 8'h22;
      sys_in = 8'h4C; upd_pass(); sig = step8(sig) ^ 8'h4C;
      chk("R9 signature after passes", core_in, sig);
      dr_scan(16, 0, d);
      chk("R9 signature scanned out", d[15:0], {8'h00, sig});
   endtask

   task automatic t_prpg();
      logic [63:0] d;
      logic [7:0] pat;
      load(8'h8D);
      dr_scan(16, 64'h0100, d);
      pat = step8(8'h01);
      chk("R10 first pattern", pin_out, pat);
      for (int i = 0; i < 3; i++) begin
         upd_pass();
         pat = step8(pat);
         chk("R10 pattern step", pin_out, pat);
      end
   endtask

   task automatic t_count();
      logic [63:0] d;
      logic [7:0] sig;
      load(8'h8E);
      sys_in = 8'h07;
      dr_scan(16, 64'hFE00, d);
      sig = step8(8'h00) ^ 8'h07;
      chk("R11 count increments", pin_out, 8'hFF);
      upd_pass();
      sig = step8(sig) ^ 8'h07;
      chk("R11 count wraps", pin_out, 8'h00);
      dr_scan(16, 0, d);
      chk("R11 signature with count", d[15:0], {8'h00, sig});
   endtask

   task automatic t_toggle();
      logic [63:0] d;
      load(8'h90);
      sys_in = 8'h6E;
      dr_scan(16, 64'h0F00, d);
      chk("R12 first inversion", pin_out, 8'hF0);
      chk("R12 inputs sampled", core_in, 8'h6E);
      upd_pass();
      chk("R12 second inversion", pin_out, 8'h0F);
      sys_in = 8'h33;
      upd_pass();
      dr_scan(16, 0, d);
      chk("R12 toggle scan out", d[15:0], {8'hF0, 8'h33});
      repeat (5) tk(1);
      tk(0);
      chk("R1 reset returns pins", {pin_oe, pin_out}, {core_oe, core_out});
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      t_reset();
      t_tlr_from_shift();
      t_bypass();
      t_parity();
      t_sample();
      t_extest();
      t_clamp_highz();
      t_psa();
      t_prpg();
      t_count();
      t_toggle();
      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (100000) @(posedge tck);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         summary();
         $finish;
      end
   end

endmodule